// File: doc/BRIEF.md
# Sequential Byte Multiplier with Status Flags

This block performs the byte multiply of an 8-bit accumulator-style datapath. It takes two unsigned operands (the accumulator value and the auxiliary register value), forms their 16-bit product, and returns it split across two bytes: the low byte goes back to the accumulator and the high byte to the auxiliary register. It also produces the two status-word bits that the multiply affects: the overflow bit reports whether the product does not fit in one byte, and the carry bit is forced to zero. Instruction decode and the register file live outside; the surrounding datapath writes the returned bytes and flag bits back into its own storage when `done` pulses.

A request is offered with a valid/ready pair. `in_ready` is high only while the unit is idle, so back-pressure is simple: a request is taken on the rising edge where `in_valid` and `in_ready` are both high. Raising `in_valid` while `in_ready` is low has no effect, and the requester may drop it again at any time. The result side has no back-pressure. `done` is a one-clock pulse, and the consumer must take `res_lo`, `res_hi`, `flag_ov` and `flag_cy` in that clock or read them later, since they hold until the next result.

Internally the product is built by shift-and-add, one multiplier bit per clock. The result is still released only after a fixed latency of four machine cycles of twelve clocks each (48 clocks with default parameters), so the instruction timing does not depend on operand values.

Top module: `mul8_unit`

## Requirements
- R1: At the `done` pulse, `res_lo` equals bits 7..0 of the unsigned product `op_a * op_b` of the accepted request.
- R2: At the `done` pulse, `res_hi` equals bits 15..8 of that product.
- R3: At the `done` pulse, `flag_ov` is 1 when the product is greater than 255 and 0 otherwise.
- R4: At the `done` pulse, `flag_cy` is 0 for every operand pair.
- R5: `done` is high for exactly one clock, 48 clock edges after the edge that accepted the request (default parameters), and never without an accepted request.
- R6: `in_ready` goes low at the accepting edge and stays low until the `done` cycle. `in_valid` raised while `in_ready` is low changes neither the result, nor its timing, nor the number of `done` pulses.
- R7: `res_lo`, `res_hi`, `flag_ov` and `flag_cy` change only at the edge that raises `done`, and hold their values otherwise.
- R8: During reset `in_ready` is 1, `done` is 0, and all result bytes and flags are 0.
- R9: `in_ready` is high during the `done` cycle, so a new request can be accepted at the edge that ends it (back-to-back issue).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to take a request |
| op_a | input | 8 | Accumulator operand, unsigned |
| op_b | input | 8 | Auxiliary-register operand, unsigned |
| done | output | 1 | One-clock pulse: result and flags are valid |
| res_lo | output | 8 | Low product byte, for the accumulator |
| res_hi | output | 8 | High product byte, for the auxiliary register |
| flag_ov | output | 1 | Overflow bit for the status word |
| flag_cy | output | 1 | Carry bit for the status word (always 0 at done) |

## Verification
The hardest case to reach from the ports is a request offered while the unit is busy. It must leave no trace. The stimulus holds `in_valid` high with different operands for many clocks during an operation, so any leak would appear as a wrong product, a shifted `done` cycle or an extra `done` pulse. A final count compares `done` pulses with accepted requests. Back-to-back issue is reached by having the driver wait on `in_ready`, which puts the next request in the `done` cycle itself. A check then confirms that acceptance landed in exactly that cycle. The operand pairs 15×17, 16×16 and 128×2 sit on either side of the one-byte boundary of the overflow flag.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } mul_phase_e;
endpackage

// File: rtl/mul_shift_add.sv
// Radix-2 shift-and-add engine: one multiplier bit per step.
module mul_shift_add #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplr;
  logic [PW-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
      mplr  <= '0;
      acc   <= '0;
    end else if (load) begin
      mcand <= {{W{1'b0}}, a};
      mplr  <= b;
      acc   <= '0;
    end else if (step && (mplr != '0)) begin
      if (mplr[0]) acc <= acc + mcand;
      mcand <= mcand << 1;
      mplr  <= mplr >> 1;
    end
  end

  assign product = acc;
endmodule

// File: rtl/mul_latency_timer.sv
// Fixed-latency sequencer: fire marks the last busy cycle.
module mul_latency_timer
  import mul8_pkg::*;
#(
  parameter int LAT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  mul_phase_e   phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_BUSY;
          cnt   <= CW'(LAT - 1);
        end
        PH_BUSY: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase == PH_BUSY);
  assign fire = busy && (cnt == '0);
endmodule

// File: rtl/mul_flag_gen.sv
// Status bits produced by the multiply.
module mul_flag_gen #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] product,
  output logic           ov,
  output logic           cy
);
  assign ov = |product[2*W-1:W];
  assign cy = 1'b0;
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit #(
  parameter int W             = 8,
  parameter int CLKS_PER_MCYC = 12,
  parameter int MCYCLES       = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         flag_ov,
  output logic         flag_cy
);
  // Latency must exceed W so the engine finishes before release.
  localparam int LATENCY = CLKS_PER_MCYC * MCYCLES;

  logic           busy;
  logic           fire;
  logic           accept;
  logic [2*W-1:0] product;
  logic           ov_n;
  logic           cy_n;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mul_latency_timer #(.LAT(LATENCY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .fire  (fire)
  );

  mul_shift_add #(.W(W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (busy),
    .a       (op_a),
    .b       (op_b),
    .product (product)
  );

  mul_flag_gen #(.W(W)) u_flags (
    .product (product),
    .ov      (ov_n),
    .cy      (cy_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      res_lo  <= '0;
      res_hi  <= '0;
      flag_ov <= 1'b0;
      flag_cy <= 1'b0;
    end else begin
      done <= fire;
      if (fire) begin
        res_lo  <= product[W-1:0];
        res_hi  <= product[2*W-1:W];
        flag_ov <= ov_n;
        flag_cy <= cy_n;
      end
    end
  end
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk #(
  parameter int W   = 8,
  parameter int LAT = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi,
  input logic         flag_ov,
  input logic         flag_cy
);
  localparam int LW = $clog2(LAT + 1) + 1;

  logic          trk;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk <= 1'b0;
      lat <= '0;
    end else if (in_valid && in_ready) begin
      trk <= 1'b1;
      lat <= '0;
    end else if (done) begin
      trk <= 1'b0;
    end else if (trk) begin
      lat <= lat + 1'b1;
    end
  end

  // R6
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trk && lat == LW'(LAT)));
  // R9
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
  // R4
  cy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_cy);
  // R3
  ov_matches_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_ov == (res_hi != '0)));
  // R7
  hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_lo));
  // R7
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hi) && $stable(flag_ov)));
endmodule

bind mul8_unit mul8_unit_chk #(.W(W), .LAT(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .flag_ov  (flag_ov),
  .flag_cy  (flag_cy)
);

// File: tb/tb_mul8_unit.sv
module tb_mul8_unit;
  localparam int LAT = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] op_a, op_b;
  logic       done;
  logic [7:0] res_lo, res_hi;
  logic       flag_ov, flag_cy;

  always #5 clk = ~clk;

  mul8_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .done(done), .res_lo(res_lo), .res_hi(res_hi),
    .flag_ov(flag_ov), .flag_cy(flag_cy)
  );

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       ov;
    int         due;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   sent = 0;
  int   seen = 0;
  int   last_done_cyc = -1;
  int   last_send_cyc = -2;
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    p = 16'(a) * 16'(b);
    last_send_cyc = cyc;
    sb.push_back('{p[7:0], p[15:8], (p > 16'd255), cyc + 1 + LAT});
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
    // R6 ready drops once taken
    chk(in_ready == 1'b0, "R6", "in_ready after accept", int'(in_ready), 0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        exp_t e;
        seen++;
        last_done_cyc = cyc;
        chk(!prev_done, "R5", "done longer than one clock", 1, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R5", "done without request", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(res_lo == e.lo, "R1", "low byte", res_lo, e.lo);
          chk(res_hi == e.hi, "R2", "high byte", res_hi, e.hi);
          chk(flag_ov == e.ov, "R3", "overflow flag", flag_ov, e.ov);
          chk(flag_cy == 1'b0, "R4", "carry flag", flag_cy, 0);
          chk(cyc == e.due, "R5", "done cycle", cyc, e.due);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [7:0]  hl, hh;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    chk(done == 1'b0, "R8", "done in reset", done, 0);
    chk({res_hi, res_lo} == 16'h0, "R8", "result in reset", {res_hi, res_lo}, 0);
    chk({flag_ov, flag_cy} == 2'b00, "R8", "flags in reset", {flag_ov, flag_cy}, 0);
    rst_n = 1'b1;

    // Corner operands around the one-byte boundary
    send(8'd0, 8'd0);     drain();
    send(8'd255, 8'd255); drain();
    send(8'd16, 8'd16);   drain();
    send(8'd15, 8'd17);   drain();
    send(8'd1, 8'd255);   drain();
    send(8'd255, 8'd0);   drain();
    send(8'd128, 8'd2);   drain();

    // R6 requests while busy are ignored
    send(8'd13, 8'd11);
    repeat (10) begin
      @(negedge clk);
      op_a = 8'd200; op_b = 8'd201; in_valid = 1'b1;
      chk(in_ready == 1'b0, "R6", "in_ready while busy", in_ready, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R7 outputs hold between results
    hl = res_lo; hh = res_hi;
    repeat (20) @(negedge clk);
    chk(res_lo == hl, "R7", "res_lo held", res_lo, hl);
    chk(res_hi == hh, "R7", "res_hi held", res_hi, hh);

    // R9 back-to-back issue in the done cycle
    send(8'd3, 8'd5);
    send(8'd7, 8'd9);
    chk(last_send_cyc == last_done_cyc, "R9", "accept in done cycle",
        last_send_cyc, last_done_cyc);
    drain();

    // Pseudo-random operands, issued back to back
    lf = 16'hACE1;
    for (int i = 0; i < 10; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[7:0], lf[15:8]);
    end
    drain();

    repeat (60) @(negedge clk);
    // R6 no extra done pulses from ignored requests
    chk(seen == sent, "R6", "done pulse count", seen, sent);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule